// File: doc/BRIEF.md
# Multi-Level DMA Address Sequencer

This block is the address and progress engine of a single DMA channel. A transfer has three nested levels. Buffers of up to 128 bytes make up a block of up to 65536 bytes, and a block is repeated up to 4096 times. The block does not move any data. It presents the current source and destination byte addresses together with a beat-valid strobe. Each beat the consumer acknowledges moves both pointers by one step. The bytes left in the current block are counted down, and a sticky flag is raised each time a buffer, a block, the last repeat or the whole channel finishes.

Software programs the configuration fields and pulses `start`. The channel then waits for request strobes. Each request runs exactly one unit of work, and the trigger mode selects the unit: a buffer, a block, all repeated blocks, or the full transfer. The block then stops issuing beats until the next request arrives. Between blocks, each pointer moves on from where the last block ended by its own signed offset. A zero offset continues contiguously.

The control is a three-state machine:
- **IDLE**: the channel is stopped.
  - IDLE→WAIT on `start` with `chan_en` high and a legal length.
  - IDLE→IDLE with the alignment flag set on `start` with an illegal length.
- **WAIT**: the channel is armed and waiting for a request.
  - WAIT→RUN on `req`.
  - WAIT→IDLE when `chan_en` drops.
- **RUN**: beats are issued.
  - RUN→WAIT when the selected unit ends.
  - RUN→IDLE when the last block of the last repeat ends, or when `chan_en` drops (abort).

Top module: `dma_level_sequencer`

## Requirements
- R1: After reset, `beat_valid`, `req_active`, `irq`, `flags` and `blk_remain` are all zero, and both addresses are zero.
- R2: `cfg_trig` selects the unit each request runs: 0 a buffer, 1 a block, 2 all repeated blocks, 3 the full transfer. When that unit's last beat is acknowledged, `beat_valid` is low in the next cycle and stays low until a new request.
- R3: Each pointer mode is 0 fixed, 1 increment, 2 decrement or 3 fixed. The step is `1 << cfg_size` bytes. Addresses change only on an acknowledged beat.
- R4: When the last beat of a block that is not the final block is acknowledged, each pointer becomes its stepped address plus its 17-bit sign-extended block offset.
- R5: `blk_remain` is loaded with `cfg_blk_len` at start and drops by the step on every acknowledged beat. It reloads at each block end and is 0 after the final block.
- R6: A buffer ends when `cfg_buf_len`+1 bytes have been moved since the buffer began, or when the block ends.
- R7: `flags` bits are sticky: bit 0 buffer done, bit 1 block done, bit 2 all repeats done, bit 3 channel complete, bit 4 alignment error. A 1 in `flag_clr` clears the matching bit and leaves the others.
- R8: `irq` is high exactly when some flag is set whose `irq_en` bit is set.
- R9: `req_active` is high exactly while the channel is serving a request, that is, while beats are issued.
- R10: A `start` whose `cfg_blk_len` is zero or not a multiple of the step sets flag bit 4. The channel stays idle and issues no beats.
- R11: Dropping `chan_en` while running returns the channel to idle in the next cycle. The beat of that cycle does not count, and the channel-complete flag is not raised. `start` is ignored while `chan_en` is low.
- R12: `req` has no effect while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| start | input | 1 | Start pulse, loads base addresses and counts |
| req | input | 1 | Request strobe, runs one unit of work |
| cfg_trig | input | 2 | Unit per request (R2 encoding) |
| cfg_src_mode | input | 2 | Source pointer mode (R3 encoding) |
| cfg_dst_mode | input | 2 | Destination pointer mode (R3 encoding) |
| cfg_size | input | 2 | Step size, 1 << value bytes |
| cfg_buf_len | input | 7 | Buffer length minus one, in bytes |
| cfg_blk_len | input | 17 | Block length in bytes, 1 to 65536 |
| cfg_rpt | input | 12 | Number of blocks minus one |
| cfg_src_base | input | 32 | Source start address |
| cfg_dst_base | input | 32 | Destination start address |
| cfg_src_off | input | 17 | Signed source offset between blocks |
| cfg_dst_off | input | 17 | Signed destination offset between blocks |
| beat_ack | input | 1 | Current beat accepted |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| irq_en | input | 5 | Per-flag interrupt enables |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| beat_valid | output | 1 | A beat is presented |
| blk_remain | output | 17 | Bytes left in the current block |
| req_active | output | 1 | A request is being served |
| flags | output | 5 | Sticky status flags (R7 positions) |
| irq | output | 1 | Interrupt |

## Verification
A request registered at one rising edge puts the first beat on the ports after that edge. An acknowledged beat updates the addresses, `blk_remain` and the flags at the next edge. A start or a flag clear takes effect at the edge that samples it. `irq` follows the flags and enables with no register in between. The bench drives every input on the falling edge and compares each output at the falling edge that follows the rising edge where the result is due. The beat loop therefore checks the model's next addresses one cycle after each acknowledged beat, and checks the stopped state one cycle after a unit's last beat.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        TRIG_BUFFER = 2'd0,
        TRIG_BLOCK  = 2'd1,
        TRIG_REPEAT = 2'd2,
        TRIG_FULL   = 2'd3
    } trig_t;

    typedef enum logic [1:0] {
        PTR_FIXED = 2'd0,
        PTR_INC   = 2'd1,
        PTR_DEC   = 2'd2,
        PTR_HOLD  = 2'd3
    } ptr_mode_t;

    localparam int FLAG_N    = 5;
    localparam int F_BUF     = 0;
    localparam int F_BLK     = 1;
    localparam int F_RPT     = 2;
    localparam int F_CHAN    = 3;
    localparam int F_ALIGN   = 4;

    function automatic logic [3:0] step_of(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    function automatic logic [2:0] low_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'b000;
            2'd1:    return 3'b001;
            2'd2:    return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/dmaseq_ptr.sv
module dmaseq_ptr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic              jump,
    input  logic [1:0]        mode,
    input  logic [3:0]        step,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    import dmaseq_pkg::*;

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] off_ext;

    always_comb begin
        off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        unique case (ptr_mode_t'(mode))
            PTR_INC: stepped = addr + ADDR_W'(step);
            PTR_DEC: stepped = addr - ADDR_W'(step);
            default: stepped = addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (advance) begin
            addr <= jump ? (stepped + off_ext) : stepped;
        end
    end

    a_r3_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !jump && (mode == 2'd0 || mode == 2'd3)) |=> $stable(addr));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(addr));

endmodule

// File: rtl/dmaseq_levels.sv
module dmaseq_levels #(
    parameter int BUF_W = 7,
    parameter int BLK_W = 17,
    parameter int RPT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [3:0]       step,
    input  logic [BUF_W-1:0] buf_len,
    input  logic [BLK_W-1:0] blk_len,
    input  logic [RPT_W-1:0] rpt,
    output logic [BLK_W-1:0] blk_remain,
    output logic             evt_buf,
    output logic             evt_blk,
    output logic             evt_rpt
);
    localparam int BC_W = BUF_W + 2;

    logic [BC_W-1:0]  buf_cnt;
    logic [RPT_W-1:0] rpt_left;
    logic [BC_W-1:0]  buf_sum;
    logic [BC_W-1:0]  buf_lim;

    always_comb begin
        buf_sum = buf_cnt + BC_W'(step);
        buf_lim = BC_W'(buf_len) + BC_W'(1);
        evt_blk = (blk_remain == BLK_W'(step));
        evt_buf = evt_blk || (buf_sum >= buf_lim);
        evt_rpt = evt_blk && (rpt_left == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_remain <= '0;
            buf_cnt    <= '0;
            rpt_left   <= '0;
        end else if (load) begin
            blk_remain <= blk_len;
            buf_cnt    <= '0;
            rpt_left   <= rpt;
        end else if (advance) begin
            if (evt_blk) begin
                buf_cnt <= '0;
                if (evt_rpt) begin
                    blk_remain <= '0;
                end else begin
                    blk_remain <= blk_len;
                    rpt_left   <= rpt_left - RPT_W'(1);
                end
            end else begin
                blk_remain <= blk_remain - BLK_W'(step);
                buf_cnt    <= evt_buf ? '0 : buf_sum;
            end
        end
    end

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (blk_remain >= BLK_W'(step)));

    a_r6_buf_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (buf_cnt < buf_lim));

endmodule

// File: rtl/dmaseq_flags.sv
module dmaseq_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] flags,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr) | set;
        end
    end

    always_comb begin
        irq = |(flags & irq_en);
    end

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

endmodule

// File: rtl/dma_level_sequencer.sv
module dma_level_sequencer #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 17,
    parameter int BUF_W  = 7,
    parameter int BLK_W  = 17,
    parameter int RPT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              start,
    input  logic              req,
    input  logic [1:0]        cfg_trig,
    input  logic [1:0]        cfg_src_mode,
    input  logic [1:0]        cfg_dst_mode,
    input  logic [1:0]        cfg_size,
    input  logic [BUF_W-1:0]  cfg_buf_len,
    input  logic [BLK_W-1:0]  cfg_blk_len,
    input  logic [RPT_W-1:0]  cfg_rpt,
    input  logic [ADDR_W-1:0] cfg_src_base,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic [OFF_W-1:0]  cfg_src_off,
    input  logic [OFF_W-1:0]  cfg_dst_off,
    input  logic              beat_ack,
    input  logic [4:0]        flag_clr,
    input  logic [4:0]        irq_en,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              beat_valid,
    output logic [BLK_W-1:0]  blk_remain,
    output logic              req_active,
    output logic [4:0]        flags,
    output logic              irq
);
    import dmaseq_pkg::*;

    seq_state_t state, state_nx;

    logic [3:0]        step;
    logic              misalign;
    logic              start_ok;
    logic              do_load;
    logic              err_set;
    logic              beat_done;
    logic              evt_buf, evt_blk, evt_rpt;
    logic              unit_end;
    logic              jump;
    logic [FLAG_N-1:0] flag_set;

    always_comb begin
        step      = step_of(cfg_size);
        misalign  = (cfg_blk_len == '0) || ((cfg_blk_len[2:0] & low_mask(cfg_size)) != 3'b000);
        start_ok  = (state == ST_IDLE) && start && chan_en;
        do_load   = start_ok && !misalign;
        err_set   = start_ok && misalign;
        beat_done = (state == ST_RUN) && chan_en && beat_ack;
        jump      = evt_blk && !evt_rpt;
        unique case (trig_t'(cfg_trig))
            TRIG_BUFFER: unit_end = evt_buf;
            TRIG_BLOCK:  unit_end = evt_blk;
            TRIG_REPEAT: unit_end = evt_rpt;
            TRIG_FULL:   unit_end = evt_rpt;
        endcase
        flag_set           = '0;
        flag_set[F_BUF]    = beat_done && evt_buf;
        flag_set[F_BLK]    = beat_done && evt_blk;
        flag_set[F_RPT]    = beat_done && evt_rpt;
        flag_set[F_CHAN]   = beat_done && evt_rpt;
        flag_set[F_ALIGN]  = err_set;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (do_load) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!chan_en)  state_nx = ST_IDLE;
                else if (req)  state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!chan_en)                  state_nx = ST_IDLE;
                else if (beat_ack && evt_rpt)  state_nx = ST_IDLE;
                else if (beat_ack && unit_end) state_nx = ST_WAIT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        beat_valid = 1'b0;
        req_active = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: ;
            ST_RUN: begin
                beat_valid = 1'b1;
                req_active = 1'b1;
            end
            default: ;
        endcase
    end

    dmaseq_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_src_ptr (
        .clk(clk), .rst_n(rst_n), .load(do_load), .base(cfg_src_base),
        .advance(beat_done), .jump(jump), .mode(cfg_src_mode), .step(step),
        .offset(cfg_src_off), .addr(src_addr)
    );

    dmaseq_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dst_ptr (
        .clk(clk), .rst_n(rst_n), .load(do_load), .base(cfg_dst_base),
        .advance(beat_done), .jump(jump), .mode(cfg_dst_mode), .step(step),
        .offset(cfg_dst_off), .addr(dst_addr)
    );

    dmaseq_levels #(.BUF_W(BUF_W), .BLK_W(BLK_W), .RPT_W(RPT_W)) u_levels (
        .clk(clk), .rst_n(rst_n), .load(do_load), .advance(beat_done),
        .step(step), .buf_len(cfg_buf_len), .blk_len(cfg_blk_len), .rpt(cfg_rpt),
        .blk_remain(blk_remain), .evt_buf(evt_buf), .evt_blk(evt_blk), .evt_rpt(evt_rpt)
    );

    dmaseq_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
        .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    a_r10_no_beat_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> (!beat_valid && state == ST_IDLE));

    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !chan_en) |=> (!req_active && !beat_valid));

    a_r2_stop_after_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && unit_end) |=> !beat_valid);

    a_r12_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> !beat_valid);

endmodule

// File: tb/tb_dma_level_sequencer.sv
`timescale 1ns/1ps
module tb_dma_level_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b1, start = 1'b0, req = 1'b0, beat_ack = 1'b0;
    logic [1:0]  cfg_trig = '0, cfg_src_mode = '0, cfg_dst_mode = '0, cfg_size = '0;
    logic [6:0]  cfg_buf_len = '0;
    logic [16:0] cfg_blk_len = '0;
    logic [11:0] cfg_rpt = '0;
    logic [31:0] cfg_src_base = 32'h1000, cfg_dst_base = 32'h8000;
    logic [16:0] cfg_src_off = '0, cfg_dst_off = '0;
    logic [4:0]  flag_clr = '0, irq_en = '0;
    logic [31:0] src_addr, dst_addr;
    logic        beat_valid, req_active, irq;
    logic [16:0] blk_remain;
    logic [4:0]  flags;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_level_sequencer dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start), .req(req),
        .cfg_trig(cfg_trig), .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_size(cfg_size), .cfg_buf_len(cfg_buf_len), .cfg_blk_len(cfg_blk_len),
        .cfg_rpt(cfg_rpt), .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
        .cfg_src_off(cfg_src_off), .cfg_dst_off(cfg_dst_off), .beat_ack(beat_ack),
        .flag_clr(flag_clr), .irq_en(irq_en), .src_addr(src_addr), .dst_addr(dst_addr),
        .beat_valid(beat_valid), .blk_remain(blk_remain), .req_active(req_active),
        .flags(flags), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mv(input logic [31:0] a, input logic [1:0] m, input int st);
        if (m == 2'd1) return a + st;
        if (m == 2'd2) return a - st;
        return a;
    endfunction

    function automatic logic [31:0] sx(input logic [16:0] o);
        return {{15{o[16]}}, o};
    endfunction

    task automatic run_xfer(input logic [1:0] tr, input logic [1:0] sm, input logic [1:0] dm,
                            input logic [1:0] sz, input logic [6:0] bl, input logic [16:0] kl,
                            input logic [11:0] rp, input logic [16:0] so, input logic [16:0] dof);
        logic [31:0] es, ed;
        logic [16:0] rem;
        logic [3:0]  ef;
        int bc, rl, step;
        bit done, ue, be, fe, re;
        step = 1 << sz;
        @(negedge clk);
        cfg_trig = tr; cfg_src_mode = sm; cfg_dst_mode = dm; cfg_size = sz;
        cfg_buf_len = bl; cfg_blk_len = kl; cfg_rpt = rp; cfg_src_off = so; cfg_dst_off = dof;
        flag_clr = 5'h1F;
        @(negedge clk);
        flag_clr = 5'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!req_active && !beat_valid && blk_remain == kl, "R5 R9 armed", {req_active, blk_remain}, {1'b0, kl});
        es = cfg_src_base; ed = cfg_dst_base; rem = kl; bc = 0; rl = int'(rp); ef = '0; done = 0;
        while (!done) begin
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            ue = 0;
            while (!ue) begin
                chk(beat_valid && req_active && src_addr == es && dst_addr == ed && blk_remain == rem,
                    "R3 R4 R5 R9 beat", {src_addr, dst_addr}, {es, ed});
                beat_ack = 1'b1;
                be = (int'(rem) == step);
                fe = be || (bc + step >= int'(bl) + 1);
                re = be && (rl == 0);
                es = mv(es, sm, step) + ((be && !re) ? sx(so) : 32'd0);
                ed = mv(ed, dm, step) + ((be && !re) ? sx(dof) : 32'd0);
                if (be) begin
                    bc = 0;
                    if (re) rem = '0;
                    else begin rem = kl; rl = rl - 1; end
                end else begin
                    rem = rem - 17'(step);
                    bc = fe ? 0 : bc + step;
                end
                ef = ef | {re, re, be, fe};
                case (tr)
                    2'd0:    ue = fe;
                    2'd1:    ue = be;
                    default: ue = re;
                endcase
                if (re) begin ue = 1; done = 1; end
                @(negedge clk);
            end
            beat_ack = 1'b0;
            chk(!beat_valid && flags[3:0] == ef, "R2 R6 R7 unit end", {beat_valid, flags}, {1'b0, 1'b0, ef});
        end
        chk(blk_remain == 0 && !req_active, "R5 final remain", blk_remain, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!beat_valid && !req_active && flags == 0 && !irq && blk_remain == 0 && src_addr == 0 && dst_addr == 0,
            "R1 reset", {beat_valid, req_active, flags, irq, blk_remain}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: request with no start
        req = 1'b1; @(negedge clk); req = 1'b0; @(negedge clk);
        chk(!beat_valid && !req_active, "R12 idle req", beat_valid, 0);

        // Sweep trigger modes, step sizes and pointer modes
        for (int t = 0; t < 4; t++)
            for (int z = 0; z < 4; z++)
                for (int m = 0; m < 4; m++) begin
                    logic [1:0] a, b;
                    case (m)
                        0: begin a = 2'd1; b = 2'd2; end
                        1: begin a = 2'd2; b = 2'd0; end
                        2: begin a = 2'd0; b = 2'd1; end
                        default: begin a = 2'd3; b = 2'd1; end
                    endcase
                    run_xfer(2'(t), a, b, 2'(z), 7'd7, 17'd16, 12'd1, 17'd4, 17'h1FFF8);
                end

        // Uneven buffer length and three blocks
        run_xfer(2'd0, 2'd1, 2'd1, 2'd1, 7'd5, 17'd12, 12'd2, 17'h1FFFC, 17'd0);

        // Largest block length
        run_xfer(2'd1, 2'd1, 2'd2, 2'd3, 7'd127, 17'h10000, 12'd0, 17'd0, 17'd0);

        // R8 / R7: interrupt masking and individual clear (flags 0..3 set by previous run)
        @(negedge clk);
        irq_en = 5'b00010;
        #1 chk(irq == 1'b1, "R8 irq on", irq, 1);
        flag_clr = 5'b00010;
        @(negedge clk);
        flag_clr = 5'b0;
        chk(flags == 5'b01101 && irq == 1'b0, "R7 R8 single clear", {flags, irq}, {5'b01101, 1'b0});
        irq_en = 5'b0;

        // R10: misaligned and zero lengths
        cfg_size = 2'd2; cfg_blk_len = 17'd6; flag_clr = 5'h1F;
        @(negedge clk);
        flag_clr = 5'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(flags[4] && !req_active, "R10 misalign flag", flags, 5'h10);
        req = 1'b1; @(negedge clk); req = 1'b0; @(negedge clk);
        chk(!beat_valid, "R10 no beats", beat_valid, 0);
        cfg_blk_len = 17'd0; flag_clr = 5'h1F;
        @(negedge clk);
        flag_clr = 5'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(flags == 5'h10, "R10 zero length", flags, 5'h10);

        // R11: abort mid-transfer
        cfg_trig = 2'd1; cfg_size = 2'd0; cfg_blk_len = 17'd16; cfg_rpt = 12'd0;
        cfg_src_mode = 2'd1; cfg_dst_mode = 2'd1; flag_clr = 5'h1F;
        @(negedge clk);
        flag_clr = 5'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(beat_valid, "R11 running", beat_valid, 1);
        beat_ack = 1'b1; chan_en = 1'b0;
        @(negedge clk);
        beat_ack = 1'b0;
        chk(!beat_valid && !req_active && !flags[3] && src_addr == cfg_src_base,
            "R11 abort", {beat_valid, flags, src_addr}, {1'b0, 5'b0, cfg_src_base});
        start = 1'b1; @(negedge clk); start = 1'b0;
        req = 1'b1; @(negedge clk); req = 1'b0; @(negedge clk);
        chk(!beat_valid, "R11 start ignored when disabled", beat_valid, 0);
        chan_en = 1'b1;
        req = 1'b1; @(negedge clk); req = 1'b0; @(negedge clk);
        chk(!beat_valid && !req_active, "R12 req after abort", beat_valid, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule